// File: doc/BRIEF.md
# Synchronous DRAM Row/Column Address Sequencer

This block turns a single-word memory request into the short command sequence that a synchronous DRAM of 4M four-bit words expects. A requester offers a 22-bit linear word address, a read or write flag and, for writes, a 4-bit data word. The address is far wider than the 12 shared address pins. The block therefore sends it in two parts on separate clock cycles: first the upper part with an open-row command, then, after a fixed pause, the lower part with the read or write command.

For a read, the block waits a fixed number of cycles for the device to answer. It then captures the 4-bit word and returns it with a one-cycle valid pulse. Every access ends with a close-row command. A new request is taken only after that command has gone out. All outputs are functions of registers and change only on the rising clock edge. Power-up initialisation, refresh, bursts and bank interleaving are not handled.

Top module: `sdr_addr_seq`

## Requirements
- R1: While reset is held, and in the first cycle after release, `req_ready` is 1, `mem_cmd` is 000 (no-op), `rsp_valid` is 0 and `mem_dq_oe` is 0.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from the cycle after acceptance up to and including the close-row cycle, and is 1 again in the cycle right after it.
- R3: In the cycle after acceptance, `mem_cmd` is 001 (open row) and `mem_addr` carries address bits 21..10 of the accepted request.
- R4: Exactly two cycles with `mem_cmd` 000 lie between the open-row cycle and the column command.
- R5: The column command is 010 for a read or 011 for a write. During it, `mem_addr` carries address bits 9..0 in pins 9..0, with pins 11..10 at zero.
- R6: `mem_dq_oe` is 1 only in the write column cycle, and during that cycle `mem_dq_out` equals the accepted write data.
- R7: For a read whose column command sits in cycle c, the block samples `mem_dq_in` at the end of cycle c+2. In cycle c+3 it shows that word on `rsp_rdata` together with a single-cycle `rsp_valid` pulse.
- R8: Exactly one close-row command (100) ends each access. It comes in cycle c+1 after a write column command in cycle c, and in cycle c+3 after a read column command in cycle c.
- R9: A write never produces an `rsp_valid` pulse.
- R10: The request inputs are ignored while `req_ready` is 0. Changing `req_addr`, `req_write`, `req_wdata` or `req_valid` during an access does not change the addresses, commands or data that the access sends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to accept |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 22 | Linear word address |
| req_wdata | input | 4 | Write data word |
| mem_cmd | output | 3 | Device command: 000 no-op, 001 open row, 010 read, 011 write, 100 close row |
| mem_addr | output | 12 | Multiplexed row/column address pins |
| mem_dq_out | output | 4 | Data toward the device |
| mem_dq_oe | output | 1 | Data output enable toward the device |
| mem_dq_in | input | 4 | Data from the device |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 4 | Returned read word |

## Verification
The embedded properties assume that the device answers a read on `mem_dq_in` exactly two cycles after the read command. They also assume that the requester does not expect acceptance while `req_ready` is low. The bench's memory model drives `mem_dq_in` with the stored word only in that one cycle and with the inverted word otherwise, so a capture taken in the wrong cycle shows up in the returned data. The driver presents each request only in a cycle where `req_ready` is high. While an access is in flight it deliberately scribbles other values onto the request inputs, so the properties about acceptance are exercised against hostile but legal stimulus.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;
   typedef enum logic [2:0] {
      CMD_NOP = 3'b000,
      CMD_ACT = 3'b001,
      CMD_RD  = 3'b010,
      CMD_WR  = 3'b011,
      CMD_PRE = 3'b100
   } sdr_cmd_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPEN,
      ST_GAP,
      ST_COL,
      ST_LAT,
      ST_CLOSE
   } sdr_state_e;
endpackage

// File: rtl/sdr_addr_split.sv
module sdr_addr_split #(
   parameter int ADDR_W = 22,
   parameter int COL_W  = 10,
   parameter int PIN_W  = 12
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [PIN_W-1:0]  row_pins,
   output logic [PIN_W-1:0]  col_pins
);
   localparam int ROW_W = ADDR_W - COL_W;

   generate
      if (ROW_W > PIN_W || COL_W > PIN_W || ROW_W < 1 || COL_W < 1) begin : g_bad_split
         $error("sdr_addr_split: row or column part does not fit the pins");
      end
      if (ROW_W == PIN_W) begin : g_row_full
         assign row_pins = addr[ADDR_W-1:COL_W];
      end else begin : g_row_ext
         assign row_pins = {{(PIN_W-ROW_W){1'b0}}, addr[ADDR_W-1:COL_W]};
      end
      if (COL_W == PIN_W) begin : g_col_full
         assign col_pins = addr[COL_W-1:0];
      end else begin : g_col_ext
         assign col_pins = {{(PIN_W-COL_W){1'b0}}, addr[COL_W-1:0]};
      end
   endgenerate
endmodule

// File: rtl/sdr_seq_fsm.sv
module sdr_seq_fsm
   import sdr_seq_pkg::*;
#(
   parameter int GAP_NOPS = 2,
   parameter int CAS_LAT  = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     req_valid,
   input  logic     req_write,
   output logic     req_ready,
   output logic     take,
   output sdr_cmd_e cmd
);
   localparam int CNT_MAX = (GAP_NOPS > CAS_LAT) ? GAP_NOPS : CAS_LAT;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   generate
      if (GAP_NOPS < 2) begin : g_bad_gap
         $error("sdr_seq_fsm: at least two idle cycles needed before the column command");
      end
      if (CAS_LAT < 1) begin : g_bad_lat
         $error("sdr_seq_fsm: read latency must be at least one");
      end
   endgenerate

   sdr_state_e       state, state_nx;
   logic [CNT_W-1:0] cnt, cnt_nx;
   logic             is_wr;

   assign req_ready = (state == ST_IDLE);
   assign take      = req_ready && req_valid;

   always_comb begin
      state_nx = state;
      cnt_nx   = cnt;
      case (state)
         ST_IDLE:  if (req_valid) state_nx = ST_OPEN;
         ST_OPEN:  begin state_nx = ST_GAP; cnt_nx = '0; end
         ST_GAP:   begin
            if (cnt == CNT_W'(GAP_NOPS - 1)) state_nx = ST_COL;
            else cnt_nx = cnt + 1'b1;
         end
         ST_COL:   begin
            cnt_nx   = '0;
            state_nx = is_wr ? ST_CLOSE : ST_LAT;
         end
         ST_LAT:   begin
            if (cnt == CNT_W'(CAS_LAT - 1)) state_nx = ST_CLOSE;
            else cnt_nx = cnt + 1'b1;
         end
         ST_CLOSE: state_nx = ST_IDLE;
         default:  state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
         is_wr <= 1'b0;
      end else begin
         state <= state_nx;
         cnt   <= cnt_nx;
         if (take) is_wr <= req_write;
      end
   end

   always_comb begin
      case (state)
         ST_OPEN:  cmd = CMD_ACT;
         ST_COL:   cmd = is_wr ? CMD_WR : CMD_RD;
         ST_CLOSE: cmd = CMD_PRE;
         default:  cmd = CMD_NOP;
      endcase
   end

   // R4: two idle cycles precede every column command
   a_r4_gap_before_col: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_RD || cmd == CMD_WR) |-> ($past(cmd, 1) == CMD_NOP && $past(cmd, 2) == CMD_NOP));

   // R8: a write column command is followed at once by close-row
   a_r8_close_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_WR) |=> (cmd == CMD_PRE));
endmodule

// File: rtl/sdr_rd_capture.sv
module sdr_rd_capture #(
   parameter int DATA_W  = 4,
   parameter int CAS_LAT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_issued,
   input  logic [DATA_W-1:0] dq_in,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata
);
   logic [CAS_LAT-1:0] pipe;

   generate
      if (CAS_LAT == 1) begin : g_lat_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= '0;
            else        pipe <= rd_issued;
         end
      end else begin : g_lat_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= '0;
            else        pipe <= {pipe[CAS_LAT-2:0], rd_issued};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= pipe[CAS_LAT-1];
         if (pipe[CAS_LAT-1]) rsp_rdata <= dq_in;
      end
   end

   // R7: the data strobe lasts a single cycle
   a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/sdr_addr_seq.sv
module sdr_addr_seq
   import sdr_seq_pkg::*;
#(
   parameter int ADDR_W   = 22,
   parameter int COL_W    = 10,
   parameter int PIN_W    = 12,
   parameter int DATA_W   = 4,
   parameter int GAP_NOPS = 2,
   parameter int CAS_LAT  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [2:0]        mem_cmd,
   output logic [PIN_W-1:0]  mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata
);
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              wr_q;
   logic              take;
   logic [PIN_W-1:0]  row_pins, col_pins;
   sdr_cmd_e          cmd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         wr_q    <= 1'b0;
      end else if (take) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
         wr_q    <= req_write;
      end
   end

   sdr_addr_split #(.ADDR_W(ADDR_W), .COL_W(COL_W), .PIN_W(PIN_W)) u_split (
      .addr     (addr_q),
      .row_pins (row_pins),
      .col_pins (col_pins)
   );

   sdr_seq_fsm #(.GAP_NOPS(GAP_NOPS), .CAS_LAT(CAS_LAT)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_ready (req_ready),
      .take      (take),
      .cmd       (cmd)
   );

   sdr_rd_capture #(.DATA_W(DATA_W), .CAS_LAT(CAS_LAT)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_issued (cmd == CMD_RD),
      .dq_in     (mem_dq_in),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );

   assign mem_cmd    = cmd;
   assign mem_dq_out = wdata_q;
   assign mem_dq_oe  = (cmd == CMD_WR);

   always_comb begin
      case (cmd)
         CMD_ACT:         mem_addr = row_pins;
         CMD_RD, CMD_WR:  mem_addr = col_pins;
         default:         mem_addr = '0;
      endcase
   end

   // R3: open-row follows an accepted request
   a_r3_open_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_ACT) |-> $past(req_valid && req_ready));

   // R2: ready returns right after close-row
   a_r2_ready_after_close: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_PRE) |=> req_ready);

   // R7: read data is returned in the close-row cycle
   a_r7_data_with_close: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (cmd == CMD_PRE));

   // R9: writes never strobe read data
   a_r9_no_strobe_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !wr_q);
endmodule

// File: tb/sim_sdr_addr_seq.sv
module sim_sdr_addr_seq;
   typedef struct packed {
      logic        w;
      logic [21:0] a;
      logic [3:0]  d;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [21:0] req_addr = '0;
   logic [3:0]  req_wdata = '0;
   logic [2:0]  mem_cmd;
   logic [11:0] mem_addr;
   logic [3:0]  mem_dq_out;
   logic        mem_dq_oe;
   logic [3:0]  mem_dq_in = 4'h0;
   logic        rsp_valid;
   logic [3:0]  rsp_rdata;

   int checks = 0;
   int errors = 0;
   int reads_sent = 0;
   int reads_seen = 0;

   item_t exp_q[$];
   logic [3:0] shadow[logic [21:0]];
   logic [3:0] model[logic [21:0]];

   always #10 clk = ~clk;

   sdr_addr_seq u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .mem_cmd(mem_cmd), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
      .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
   );

   function automatic logic [3:0] init_word(logic [21:0] a);
      return a[3:0] ^ a[13:10] ^ a[21:18] ^ 4'h5;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // device model: stores writes, answers reads two cycles after the command
   logic [11:0] open_row = '0;
   logic [3:0]  rd_hold = '0;
   int          rd_stage = 0;
   always @(posedge clk) begin
      if (rd_stage == 2) begin
         mem_dq_in <= ~rd_hold;
         rd_stage = 0;
      end else if (rd_stage == 1) begin
         mem_dq_in <= rd_hold;
         rd_stage = 2;
      end
      if (rst_n) begin
         case (mem_cmd)
            3'b001: open_row = mem_addr;
            3'b011: model[{open_row, mem_addr[9:0]}] = mem_dq_out;
            3'b010: begin
               rd_hold = model.exists({open_row, mem_addr[9:0]}) ?
                         model[{open_row, mem_addr[9:0]}] : init_word({open_row, mem_addr[9:0]});
               rd_stage = 1;
            end
            default: ;
         endcase
      end
   end

   // driver: presents one request, scribbles the inputs while busy (R10)
   task automatic do_req(input bit w, input logic [21:0] a, input logic [3:0] d);
      item_t it;
      do @(negedge clk); while (!req_ready);
      req_valid = 1'b1;
      req_write = w;
      req_addr  = a;
      req_wdata = d;
      it.w = w;
      it.a = a;
      if (w) begin
         it.d = d;
         shadow[a] = d;
      end else begin
         it.d = shadow.exists(a) ? shadow[a] : init_word(a);
         reads_sent++;
      end
      exp_q.push_back(it);
      @(negedge clk);
      req_valid = 1'b1;
      req_write = ~w;
      req_addr  = ~a;
      req_wdata = ~d;
      while (mem_cmd != 3'b100) begin
         @(negedge clk);
         req_addr = req_addr + 22'h155;
      end
      req_valid = 1'b0;
   endtask

   // monitor / scoreboard
   item_t cur;
   bit    have_cur = 0;
   int    cyc = 0;
   int    nops = 0;
   int    col_cyc = -100;
   int    pre_cyc = -100;
   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         if (rsp_valid) begin
            reads_seen++;
            chk(have_cur && !cur.w, "R9", "strobe belongs to a read", int'(cur.w), 0);
            chk(cyc == col_cyc + 3, "R7", "strobe cycle", cyc, col_cyc + 3);
            chk(rsp_rdata == cur.d, "R7", "read data", rsp_rdata, cur.d);
         end
         chk(!(mem_dq_oe && mem_cmd != 3'b011), "R6", "oe outside write", mem_dq_oe, 0);
         if (cyc == pre_cyc + 1)
            chk(req_ready == 1'b1, "R2", "ready after close", req_ready, 1);
         case (mem_cmd)
            3'b001: begin
               chk(!have_cur && exp_q.size() > 0, "R3", "open row with pending request",
                   exp_q.size(), 1);
               if (exp_q.size() > 0) cur = exp_q.pop_front();
               have_cur = 1;
               nops = 0;
               col_cyc = -100;
               chk(mem_addr == cur.a[21:10], "R3", "row address", mem_addr, cur.a[21:10]);
               chk(req_ready == 1'b0, "R2", "busy during access", req_ready, 0);
            end
            3'b000: if (have_cur && col_cyc < 0) nops++;
            3'b010, 3'b011: begin
               chk(nops == 2, "R4", "idle cycles before column", nops, 2);
               chk(mem_cmd == (cur.w ? 3'b011 : 3'b010), "R5", "column command",
                   mem_cmd, cur.w ? 3 : 2);
               chk(mem_addr == {2'b00, cur.a[9:0]}, "R5", "column address",
                   mem_addr, {2'b00, cur.a[9:0]});
               if (cur.w) begin
                  chk(mem_dq_oe == 1'b1, "R6", "oe in write", mem_dq_oe, 1);
                  chk(mem_dq_out == cur.d, "R6", "write data", mem_dq_out, cur.d);
               end
               col_cyc = cyc;
            end
            3'b100: begin
               chk(have_cur, "R8", "close with open access", int'(have_cur), 1);
               chk(cyc == col_cyc + (cur.w ? 1 : 3), "R8", "close cycle",
                   cyc, col_cyc + (cur.w ? 1 : 3));
               pre_cyc = cyc;
               have_cur = 0;
               col_cyc = -100;
            end
            default: chk(1'b0, "R5", "illegal command code", mem_cmd, 0);
         endcase
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [21:0] ra;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
      chk(mem_cmd == 3'b000, "R1", "cmd in reset", mem_cmd, 0);
      chk(rsp_valid == 1'b0, "R1", "strobe in reset", rsp_valid, 0);
      chk(mem_dq_oe == 1'b0, "R1", "oe in reset", mem_dq_oe, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1 && mem_cmd == 3'b000, "R1", "idle after release",
          {req_ready, mem_cmd}, 4'b1000);
      // corner addresses
      do_req(1'b1, 22'h000000, 4'h3);
      do_req(1'b1, 22'h3FFFFF, 4'hC);
      do_req(1'b1, 22'h3FFC00, 4'h9);
      do_req(1'b1, 22'h0003FF, 4'h6);
      do_req(1'b0, 22'h000000, 4'h0);
      do_req(1'b0, 22'h3FFFFF, 4'h0);
      do_req(1'b0, 22'h3FFC00, 4'h0);
      do_req(1'b0, 22'h0003FF, 4'h0);
      // unwritten location and overwrite
      do_req(1'b0, 22'h12345A, 4'h0);
      do_req(1'b1, 22'h000000, 4'hE);
      do_req(1'b0, 22'h000000, 4'h0);
      // pseudo-random mix
      ra = 22'h2A5C31;
      for (int i = 0; i < 40; i++) begin
         ra = {ra[20:0], ra[21] ^ ra[20]} ^ 22'(i * 7919);
         do_req(ra[5], {ra[21:16], 6'h0, ra[9:0]} ^ 22'(i & 3), ra[15:12]);
      end
      repeat (8) @(negedge clk);
      chk(exp_q.size() == 0, "R3", "all requests issued", exp_q.size(), 0);
      chk(reads_seen == reads_sent, "R7", "read strobes", reads_seen, reads_sent);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule